// File: doc/BRIEF.md
# Serial Byte Write Receiver

This block is the front end of a display controller's serial host port. A host drives an active-low select, a data line, a bit clock and a command/data flag. The block turns that stream into 8-bit write cycles for the display memory and command path. The serial path only writes: there is no way to read back through it.

All four pins are brought into the system clock domain by a shared multi-stage synchronizer. The rising edge of the bit clock is found by an edge detector that runs on the system clock. Each rising edge taken while the port is selected shifts one data bit into a shift register, and a bit counter tracks the position inside the byte. On the last bit of a byte, the block emits the completed word as a one-cycle strobe. The word is tagged with the flag level seen on that same bit. The counter then wraps, so bytes can follow one another without releasing select. Releasing select at any point throws away a partly received byte and returns the shifter and counter to zero.

Top module: `serial_write_port`

## Requirements
- R1: While reset is asserted, and after it is released with no bit-clock activity, `wr_stb` stays 0.
- R2: Bits are assembled most significant first: the first data bit received after select ends up in `wr_word[7]` and the eighth in `wr_word[0]`.
- R3: Every eighth rising bit-clock edge taken while selected produces exactly one `wr_stb` pulse, one system clock wide.
- R4: `wr_is_data` carries the level of the flag input at the eighth rising edge of the byte (1 = display data, 0 = command). Flag levels on the seven earlier bits have no effect.
- R5: Raising select (inactive high) in the middle of a byte discards the bits already taken. The next byte after select is asserted again is assembled from its own eight bits only.
- R6: Bit-clock edges while select is high neither produce a strobe nor advance the bit position.
- R7: With select held low, consecutive bytes are received back to back. The bit counter wraps after each byte, and each byte gives its own strobe carrying its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Port select, active low, asynchronous to clk |
| ser_dat | input | 1 | Serial data bit, asynchronous to clk |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk, sampled on its rising edge |
| dc_flag | input | 1 | Command/data flag, asynchronous to clk |
| wr_stb | output | 1 | One-cycle strobe marking a completed byte |
| wr_word | output | 8 | Completed byte, valid while `wr_stb` is high |
| wr_is_data | output | 1 | 1 for a display data byte, 0 for a command byte |

## Verification
The hardest state to reach from the ports is a partly filled shifter at the moment select is released. Only a deselect that lands between two bit clocks, after some but not all bits, shows whether the counter and shifter were really cleared. The stimulus sends three-bit and seven-bit fragments filled with ones and then releases select. It also toggles the bit clock with select high. Each case is followed by a full byte whose expected value differs from what a leftover bit or count would produce. Random bytes with random flags follow back to back, and the flag is flipped on the early bits so that only its level at the eighth bit can give the right tag.

// File: rtl/swp_pkg.sv
package swp_pkg;

   // Bit order in which serial bits fill the assembled word
   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;

   // Which serial clock transition takes a bit
   typedef enum logic {
      EDGE_RISING  = 1'b0,
      EDGE_FALLING = 1'b1
   } edge_kind_e;

   // Positions inside the synchronised pin bundle
   localparam int unsigned PIN_SEL  = 0;
   localparam int unsigned PIN_DAT  = 1;
   localparam int unsigned PIN_CLK  = 2;
   localparam int unsigned PIN_FLAG = 3;
   localparam int unsigned PIN_CNT  = 4;

endpackage

// File: rtl/swp_sync.sv
module swp_sync #(
   parameter int unsigned        WIDTH   = 4,
   parameter int unsigned        STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("swp_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/swp_edge.sv
module swp_edge
   import swp_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_RISING
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic hit
);

   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   generate
      if (KIND == EDGE_RISING) begin : g_rise
         assign hit = level & ~level_q;
      end else begin : g_fall
         assign hit = ~level & level_q;
      end
   endgenerate

endmodule

// File: rtl/swp_deser.sv
module swp_deser
   import swp_pkg::*;
#(
   parameter int unsigned WORD_W = 8,
   parameter bit_order_e  ORDER  = ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              bit_stb,
   input  logic              bit_in,
   input  logic              flag_in,
   output logic              word_stb,
   output logic [WORD_W-1:0] word,
   output logic              word_flag
);

   localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("swp_deser: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              take;
   logic              at_last;

   assign take    = active & bit_stb;
   assign at_last = (cnt_q == LAST);

   generate
      if (ORDER == ORDER_MSB_FIRST) begin : g_msb
         assign sh_nxt = {sh_q[WORD_W-2:0], bit_in};
      end else begin : g_lsb
         assign sh_nxt = {bit_in, sh_q[WORD_W-1:1]};
      end
   endgenerate

   // shift register and bit position, cleared while not selected
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (!active) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (take) begin
         sh_q  <= at_last ? '0 : sh_nxt;
         cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
      end
   end

   // completed word register and strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_stb  <= 1'b0;
         word      <= '0;
         word_flag <= 1'b0;
      end else begin
         word_stb <= take & at_last;
         if (take && at_last) begin
            word      <= sh_nxt;
            word_flag <= flag_in;
         end
      end
   end

   // R5: leaving the selected state empties shifter and counter
   assert_clear_on_deselect_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0 && sh_q == '0));

   // R3: a completed word is flagged for one cycle only
   assert_single_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb);

   // R6: no strobe without a bit taken while selected
   assert_pulse_needs_edge_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> $past(bit_stb && active));

   // R6: a bit clock edge while deselected leaves the count at zero
   assert_idle_no_count_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !active) |=> cnt_q == '0);

   // R7: the counter wraps after the last bit of a word
   assert_wrap_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (take && at_last) |=> (cnt_q == '0 && word_stb));

   // R3: every other bit advances the position by one
   assert_count_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (take && !at_last) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/serial_write_port.sv
module serial_write_port
   import swp_pkg::*;
#(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LSB_FIRST   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              ser_dat,
   input  logic              ser_clk,
   input  logic              dc_flag,
   output logic              wr_stb,
   output logic [WORD_W-1:0] wr_word,
   output logic              wr_is_data
);

   localparam bit_order_e ORDER = LSB_FIRST ? ORDER_LSB_FIRST : ORDER_MSB_FIRST;
   localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_SEL;

   logic [PIN_CNT-1:0] pins_raw;
   logic [PIN_CNT-1:0] pins_s;
   logic               clk_rise;

   assign pins_raw[PIN_SEL]  = sel_n;
   assign pins_raw[PIN_DAT]  = ser_dat;
   assign pins_raw[PIN_CLK]  = ser_clk;
   assign pins_raw[PIN_FLAG] = dc_flag;

   swp_sync #(
      .WIDTH   (PIN_CNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_raw),
      .q_sync  (pins_s)
   );

   swp_edge #(
      .KIND  (EDGE_RISING)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pins_s[PIN_CLK]),
      .hit   (clk_rise)
   );

   swp_deser #(
      .WORD_W (WORD_W),
      .ORDER  (ORDER)
   ) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (~pins_s[PIN_SEL]),
      .bit_stb   (clk_rise),
      .bit_in    (pins_s[PIN_DAT]),
      .flag_in   (pins_s[PIN_FLAG]),
      .word_stb  (wr_stb),
      .word      (wr_word),
      .word_flag (wr_is_data)
   );

   // R1: no strobe in the first cycle after reset release
   assert_quiet_after_reset_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !wr_stb);

endmodule

// File: tb/serial_write_port_bench.sv
module serial_write_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1;
   logic       ser_dat = 1'b0;
   logic       ser_clk = 1'b0;
   logic       dc_flag = 1'b0;
   logic       wr_stb;
   logic [7:0] wr_word;
   logic       wr_is_data;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int sent   = 0;
   logic prev_stb = 1'b0;
   logic [8:0] expq [$];

   always #4 clk = ~clk;

   serial_write_port u_serial_write_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_n      (sel_n),
      .ser_dat    (ser_dat),
      .ser_clk    (ser_clk),
      .dc_flag    (dc_flag),
      .wr_stb     (wr_stb),
      .wr_word    (wr_word),
      .wr_is_data (wr_is_data)
   );

   function automatic logic [8:0] exp_word(input logic flag, input logic [7:0] v);
      return {flag, v};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input logic f);
      ser_clk = 1'b0; ser_dat = b; dc_flag = f;
      tick(4);
      ser_clk = 1'b1;
      tick(4);
   endtask

   // sends MSB first; flip puts the opposite flag on the first seven bits (R4)
   task automatic send_byte(input logic [7:0] v, input logic f, input logic flip);
      expq.push_back(exp_word(f, v));
      sent++;
      for (int i = 7; i >= 0; i--)
         send_bit(v[i], (i == 0) ? f : (flip ? ~f : f));
      ser_clk = 1'b0;
      tick(4);
   endtask

   // monitor: compare each strobe against the expected queue (R2 R3 R4 R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_stb) begin
            pulses++;
            checks++;
            if (expq.size() == 0) begin
               errors++;
               $display("FAIL R6 unexpected byte got %h expected none", {wr_is_data, wr_word});
            end else begin
               logic [8:0] e;
               e = expq.pop_front();
               if ({wr_is_data, wr_word} !== e) begin
                  errors++;
                  $display("FAIL R2/R4 byte got %h expected %h", {wr_is_data, wr_word}, e);
               end
            end
            if (prev_stb) begin
               errors++;
               $display("FAIL R3 strobe width got 2+ cycles expected 1");
            end
         end
         prev_stb <= wr_stb;
      end
   end

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog got timeout expected finish");
      report();
   end

   initial begin
      int p0;
      logic [7:0] rv;
      logic rf;
      void'($urandom(32'h5EED_1234));

      // R1: reset state
      tick(3);
      checks++;
      if (wr_stb !== 1'b0) begin
         errors++; $display("FAIL R1 strobe in reset got %b expected 0", wr_stb);
      end
      rst_n = 1'b1;
      tick(6);
      checks++;
      if (wr_stb !== 1'b0 || pulses != 0) begin
         errors++; $display("FAIL R1 strobe after reset got %0d expected 0", pulses);
      end

      // R2: bit order, single set bits at both ends
      sel_n = 1'b0; tick(4);
      send_byte(8'h80, 1'b1, 1'b0);
      send_byte(8'h01, 1'b0, 1'b0);
      send_byte(8'hA5, 1'b1, 1'b0);

      // R4: flag only counts on the eighth bit
      send_byte(8'h3C, 1'b0, 1'b1);
      send_byte(8'hC3, 1'b1, 1'b1);
      sel_n = 1'b1; tick(6);

      // R5: three leading ones then deselect
      sel_n = 1'b0; tick(4);
      for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
      ser_clk = 1'b0; tick(4);
      sel_n = 1'b1; tick(6);
      sel_n = 1'b0; tick(4);
      send_byte(8'h0F, 1'b0, 1'b0);
      // R5: seven bits then deselect
      for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
      ser_clk = 1'b0; tick(4);
      sel_n = 1'b1; tick(6);
      sel_n = 1'b0; tick(4);
      send_byte(8'h00, 1'b1, 1'b0);
      sel_n = 1'b1; tick(6);

      // R6: bit clock activity while deselected
      p0 = pulses;
      for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b1);
      ser_clk = 1'b0; tick(6);
      checks++;
      if (pulses != p0) begin
         errors++; $display("FAIL R6 pulses while deselected got %0d expected %0d", pulses, p0);
      end
      sel_n = 1'b0; tick(4);
      send_byte(8'h12, 1'b0, 1'b0);

      // R7: random back to back bytes
      for (int n = 0; n < 40; n++) begin
         rv = 8'($urandom);
         rf = 1'($urandom);
         send_byte(rv, rf, 1'($urandom));
      end
      sel_n = 1'b1; tick(10);

      checks++;
      if (pulses != sent) begin
         errors++; $display("FAIL R7 byte count got %0d expected %0d", pulses, sent);
      end
      checks++;
      if (expq.size() != 0) begin
         errors++; $display("FAIL R3 missing strobes got %0d left expected 0", expq.size());
      end
      report();
   end

endmodule